// File: doc/BRIEF.md
# Page Write Buffer and Self-Timed Write Engine

This block sits behind the command decoder of a serial non-volatile memory. When the decoder recognises an array-write command, it passes on the start address, followed by one strobe per fully received data byte. The engine places each byte into a 16-byte page buffer. The buffer is indexed by the low address bits, which advance and wrap inside the page, so a command can never reach outside the aligned page it started in. A bitmask records which page locations have received a byte.

When chip select returns high, the engine checks how the command ended. If at least one whole byte arrived and no partial byte is pending, it starts a self-timed write cycle. The engine then walks the sixteen page locations once, one per clock. It presents each address to the external protection unit and stores the byte only where the mask is set and permission is given. A busy flag stays high for a fixed number of system clocks, set by a parameter. At the end of the cycle the engine pulses a completion strobe, which the owner of the write-enable latch uses to clear it.

A command that carries no data byte, or that ends part-way through a byte, is discarded without a busy period. While busy, the engine ignores new commands, bytes and chip-select edges. The array is held inside the block and read through a registered read port.

Top module: `pwb_engine`

## Requirements
- R1: After reset, `busy` and `wel_clr` are 0 and every array location reads the erased value 0xFF.
- R2: A data byte is written to the page whose upper address bits are those of `start_addr`. The first byte goes to the location given by the low 4 bits of `start_addr`, and each following byte goes to the next location.
- R3: After page location 15 (low bits 1111), the next byte goes to location 0 of the same page. No other page is ever touched.
- R4: When more than 16 bytes arrive in one command, each location holds the byte most recently received for it.
- R5: Locations of the page that received no byte keep their previous contents.
- R6: The first clock edge that sees `cs_n` high after a command with at least one whole byte sets `busy` after that edge. `busy` then stays high for exactly WRITE_CYCLES clocks.
- R7: `wel_clr` is high for exactly one clock: the first clock in which `busy` is low again after a write cycle.
- R8: If the command ended with no data byte, or with `frag_pending` high when `cs_n` rose, `busy` and `wel_clr` stay 0 and the array is unchanged.
- R9: During the write cycle `perm_addr` presents each page address once. A received byte is stored only if `perm_ok` is high while its address is presented.
- R10: While `busy` is high, `wr_start`, `byte_valid` and rising edges of `cs_n` have no effect. No second write cycle follows, and the addressed page is not changed.
- R11: `rd_data` shows the array contents at `rd_addr` one clock after `rd_addr` is applied, and does not change before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select level, active low; a rise ends the command |
| wr_start | input | 1 | One-clock strobe: an array-write command with address has been decoded |
| start_addr | input | ADDR_W | Address of the first byte of the command |
| byte_valid | input | 1 | One-clock strobe: a whole data byte is on `byte_data` |
| byte_data | input | 8 | Received data byte |
| frag_pending | input | 1 | High while the shifter holds an incomplete byte |
| perm_ok | input | 1 | Write permission for `perm_addr`, from the protection unit |
| perm_addr | output | ADDR_W | Address being checked and stored during the write cycle |
| busy | output | 1 | Self-timed write cycle in progress |
| wel_clr | output | 1 | One-clock completion pulse that clears the write-enable latch |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array read data, registered |

## Verification
Some faults act at once, and the busy timing shows them right after the chip-select edge. A wrong mask or a lost armed flag gives `busy` where none is due, or none where one is due, one clock after that edge. A wrong cycle counter moves the fall of `busy` and the `wel_clr` pulse by the error, and the pulse comes at the end of the write period. Other faults corrupt the buffer or its write pointer. Those show up only in the array contents, once the write cycle has finished and a read-port sweep of the affected page compares every byte with a page model. Such a sweep exposes wrap, overflow and partial-page errors byte by byte.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   // Phases of the self-timed write cycle
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,   // no write cycle, collector may accept a command
      PH_WALK = 2'd1,   // stepping through the page locations
      PH_HOLD = 2'd2    // programming time remainder, array untouched
   } wr_phase_t;

   localparam int unsigned BYTE_W = 8;

   // page number of an address for a given page index width
   function automatic int unsigned page_of(input int unsigned addr, input int unsigned pw);
      return addr >> pw;
   endfunction

endpackage

// File: rtl/pwb_collect.sv
module pwb_collect #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_BYTES = 16,
   localparam int unsigned PW        = $clog2(PAGE_BYTES),
   localparam int unsigned PN_W      = ADDR_W - PW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_en,   // low while a write cycle runs
   input  logic              wr_start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              close,       // command ended (chip select rose)
   input  logic              drop,        // ended without a launch: forget it
   input  logic              done,        // write cycle finished
   input  logic [PW-1:0]     sel_idx,     // location read by the commit walk
   output logic [PN_W-1:0]   page_num,
   output logic              armed,
   output logic [PAGE_BYTES-1:0] got_mask,
   output logic [DATA_W-1:0] sel_byte
);

   logic [DATA_W-1:0] page_buf [PAGE_BYTES];
   logic [PW-1:0]     wptr;
   logic              take_byte;

   assign take_byte = accept_en & armed & byte_valid & ~wr_start;

   // command framing and write pointer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         wptr     <= '0;
         page_num <= '0;
      end else if (accept_en) begin
         if (wr_start) begin
            armed    <= 1'b1;
            wptr     <= start_addr[PW-1:0];
            page_num <= start_addr[ADDR_W-1:PW];
         end else begin
            if (close)     armed <= 1'b0;
            if (take_byte) wptr  <= wptr + 1'b1;   // wraps within the page
         end
      end
   end

   // received-location mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         got_mask <= '0;
      end else if (done || (accept_en && (drop || wr_start))) begin
         got_mask <= '0;
      end else if (take_byte) begin
         got_mask[wptr] <= 1'b1;
      end
   end

   // byte storage: one register per location, later byte overwrites
   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_loc
      always_ff @(posedge clk) begin
         if (take_byte && (wptr == PW'(g))) page_buf[g] <= byte_data;
      end
   end

   assign sel_byte = page_buf[sel_idx];

endmodule

// File: rtl/pwb_timer.sv
module pwb_timer
   import pwb_pkg::*;
#(
   parameter int unsigned WRITE_CYCLES = 1000000,
   parameter int unsigned PAGE_BYTES   = 16,
   localparam int unsigned PW          = $clog2(PAGE_BYTES),
   localparam int unsigned CW          = $clog2(WRITE_CYCLES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   output logic          busy,
   output logic          done,
   output logic          walk_act,
   output logic [PW-1:0] walk_idx
);

   wr_phase_t     phase;
   logic [CW-1:0] cnt;
   logic          at_end;
   logic          at_last_loc;

   assign at_end      = (cnt == CW'(WRITE_CYCLES - 1));
   assign at_last_loc = (cnt == CW'(PAGE_BYTES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_IDLE: begin
               cnt <= '0;
               if (launch) phase <= PH_WALK;
            end
            PH_WALK: begin
               cnt <= cnt + 1'b1;
               if (at_last_loc) phase <= PH_HOLD;
            end
            PH_HOLD: begin
               cnt <= cnt + 1'b1;
               if (at_end) begin
                  phase <= PH_IDLE;
                  done  <= 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign busy     = (phase != PH_IDLE);
   assign walk_act = (phase == PH_WALK);
   assign walk_idx = cnt[PW-1:0];

endmodule

// File: rtl/pwb_array.sv
module pwb_array #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter logic [7:0]  INIT_BYTE = 8'hFF,
   parameter bit          RD_REG    = 1'b1,
   localparam int unsigned DEPTH    = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   // model of the non-volatile cells, erased at reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= DATA_W'(INIT_BYTE);
      end else if (we) begin
         cells[waddr] <= wdata;
      end
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= DATA_W'(INIT_BYTE);
         else        rdata <= cells[raddr];
      end
   end else begin : g_rd_comb
      assign rdata = cells[raddr];
   end

endmodule

// File: rtl/pwb_engine.sv
module pwb_engine
   import pwb_pkg::*;
#(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned PAGE_BYTES   = 16,
   parameter int unsigned WRITE_CYCLES = 1000000,
   parameter logic [7:0]  INIT_BYTE    = 8'hFF,
   parameter bit          RD_REG       = 1'b1,
   localparam int unsigned PW          = $clog2(PAGE_BYTES),
   localparam int unsigned PN_W        = ADDR_W - PW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                wr_start,
   input  logic [ADDR_W-1:0]   start_addr,
   input  logic                byte_valid,
   input  logic [BYTE_W-1:0]   byte_data,
   input  logic                frag_pending,
   input  logic                perm_ok,
   output logic [ADDR_W-1:0]   perm_addr,
   output logic                busy,
   output logic                wel_clr,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [BYTE_W-1:0]   rd_data
);

   // elaboration-time parameter checks
   if ((PAGE_BYTES < 2) || ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (PW >= ADDR_W) begin : g_bad_addr
      $error("ADDR_W must exceed the page index width");
   end
   if (WRITE_CYCLES < PAGE_BYTES + 1) begin : g_bad_time
      $error("WRITE_CYCLES must exceed PAGE_BYTES");
   end

   logic                  cs_n_q;
   logic                  cs_rise;
   logic                  close;
   logic                  launch;
   logic                  drop;
   logic                  armed;
   logic [PAGE_BYTES-1:0] got_mask;
   logic [PN_W-1:0]       page_num;
   logic [BYTE_W-1:0]     sel_byte;
   logic                  walk_act;
   logic [PW-1:0]         walk_idx;
   logic                  done;
   logic                  mem_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_n_q <= 1'b1;
      else        cs_n_q <= cs_n;
   end

   assign cs_rise = cs_n & ~cs_n_q;
   assign close   = cs_rise & ~busy;
   assign launch  = close & armed & (|got_mask) & ~frag_pending;
   assign drop    = close & ~launch;

   pwb_collect #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (BYTE_W),
      .PAGE_BYTES(PAGE_BYTES)
   ) u_collect (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_en (~busy),
      .wr_start  (wr_start),
      .start_addr(start_addr),
      .byte_valid(byte_valid),
      .byte_data (byte_data),
      .close     (close),
      .drop      (drop),
      .done      (done),
      .sel_idx   (walk_idx),
      .page_num  (page_num),
      .armed     (armed),
      .got_mask  (got_mask),
      .sel_byte  (sel_byte)
   );

   pwb_timer #(
      .WRITE_CYCLES(WRITE_CYCLES),
      .PAGE_BYTES  (PAGE_BYTES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch),
      .busy    (busy),
      .done    (done),
      .walk_act(walk_act),
      .walk_idx(walk_idx)
   );

   assign perm_addr = {page_num, walk_idx};
   assign mem_we    = walk_act & got_mask[walk_idx] & perm_ok;
   assign wel_clr   = done;

   pwb_array #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (BYTE_W),
      .INIT_BYTE(INIT_BYTE),
      .RD_REG   (RD_REG)
   ) u_array (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (mem_we),
      .waddr(perm_addr),
      .wdata(sel_byte),
      .raddr(rd_addr),
      .rdata(rd_data)
   );

endmodule

// File: rtl/pwb_engine_chk.sv
module pwb_engine_chk #(
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned PAGE_BYTES   = 16,
   parameter int unsigned WRITE_CYCLES = 1000000,
   localparam int unsigned PW          = $clog2(PAGE_BYTES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              busy,
   input logic              wel_clr,
   input logic              perm_ok,
   input logic              mem_we,
   input logic [ADDR_W-1:0] perm_addr
);

   logic [31:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 1'b1;
      else           busy_len <= '0;
   end

   AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len == WRITE_CYCLES)); // R6

   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < WRITE_CYCLES)); // R6

   AST_BUSY_FROM_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cs_n) && !$past(cs_n, 2))); // R6

   AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clr |-> (!busy && $past(busy))); // R7

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wel_clr |=> !wel_clr); // R7

   AST_STORE_PERMITTED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (busy && perm_ok)); // R9

   AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(perm_addr[ADDR_W-1:PW])); // R3

endmodule

bind pwb_engine pwb_engine_chk #(
   .ADDR_W      (ADDR_W),
   .PAGE_BYTES  (PAGE_BYTES),
   .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n     (cs_n),
   .busy     (busy),
   .wel_clr  (wel_clr),
   .perm_ok  (perm_ok),
   .mem_we   (mem_we),
   .perm_addr(perm_addr)
);

// File: tb/test_pwb_engine.sv
`timescale 1ns/100ps
module test_pwb_engine;

   localparam int AW = 8;
   localparam int WC = 24;
   localparam int DEPTH = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          wr_start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          byte_valid = 1'b0;
   logic [7:0]    byte_data = '0;
   logic          frag_pending = 1'b0;
   logic          perm_ok;
   logic [AW-1:0] perm_addr;
   logic          busy;
   logic          wel_clr;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;
   int prot_mode = 0;       // 0 all allowed, 1 top quarter locked, 2 odd addresses locked
   logic [7:0] exp_mem [DEPTH];

   always #2.5 clk = ~clk;

   function automatic bit allowed(input int a, input int mode);
      if (mode == 1) return (a < 8'hC0);
      if (mode == 2) return (a % 2 == 0);
      return 1'b1;
   endfunction

   assign perm_ok = allowed(int'(perm_addr), prot_mode);

   pwb_engine #(.ADDR_W(AW), .PAGE_BYTES(16), .WRITE_CYCLES(WC)) i_pwb_engine (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_start(wr_start),
      .start_addr(start_addr), .byte_valid(byte_valid), .byte_data(byte_data),
      .frag_pending(frag_pending), .perm_ok(perm_ok), .perm_addr(perm_addr),
      .busy(busy), .wel_clr(wel_clr), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic sweep(input string tag);
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk) rd_addr = AW'(a);
         @(negedge clk) check(tag, int'(rd_data), int'(exp_mem[a]));
      end
   endtask

   // watch a window for absence of busy and wel_clr
   task automatic quiet(input string tag, input int n);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (busy || wel_clr) seen++;
      end
      check(tag, seen, 0);
   endtask

   // one write command; bytes are seed + 7*i
   task automatic write_cmd(input int a, input int n, input int seed, input bit frag,
                            input string tag);
      logic [7:0] pend [16];
      bit         got  [16];
      int         blen;
      bit         go;
      for (int i = 0; i < 16; i++) got[i] = 1'b0;
      @(negedge clk) cs_n = 1'b0;
      @(negedge clk) begin wr_start = 1'b1; start_addr = AW'(a); end
      @(negedge clk) wr_start = 1'b0;
      for (int i = 0; i < n; i++) begin
         byte_valid = 1'b1;
         byte_data  = 8'((seed + 7 * i) & 8'hFF);
         pend[(a + i) % 16] = byte_data;
         got[(a + i) % 16]  = 1'b1;
         @(negedge clk);
      end
      byte_valid   = 1'b0;
      frag_pending = frag;
      cs_n         = 1'b1;
      go = (n > 0) && !frag;
      @(negedge clk);
      frag_pending = 1'b0;
      check({tag, " busy after cs rise (R6/R8)"}, int'(busy), int'(go));
      if (go) begin
         blen = 0;
         while (busy && blen < 4 * WC) begin
            blen++;
            @(negedge clk);
         end
         check({tag, " busy length R6"}, blen, WC);
         check({tag, " wel_clr pulse R7"}, int'(wel_clr), 1);
         @(negedge clk);
         check({tag, " wel_clr single R7"}, int'(wel_clr), 0);
         for (int l = 0; l < 16; l++)
            if (got[l] && allowed((a & 8'hF0) | l, prot_mode))
               exp_mem[(a & 8'hF0) | l] = pend[l];
      end else begin
         check({tag, " no wel_clr R8"}, int'(wel_clr), 0);
      end
   endtask

   initial begin
      for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
      repeat (3) @(negedge clk);
      check("R1 busy at reset", int'(busy), 0);
      check("R1 wel_clr at reset", int'(wel_clr), 0);
      rst_n = 1'b1;
      sweep("R1 erased array");

      // full aligned page
      write_cmd(8'h30, 16, 8'h11, 1'b0, "R2 full page");
      sweep("R2 full page contents");

      // partial page crossing the page end: 4E, 4F, 40
      write_cmd(8'h4E, 3, 8'hA0, 1'b0, "R3 wrap");
      sweep("R3/R5 wrapped partial page");

      // overflow: 20 bytes from 52, last sixteen kept
      write_cmd(8'h52, 20, 8'h05, 1'b0, "R4 overflow");
      sweep("R4 last sixteen kept");

      // rewrite part of an already written page
      write_cmd(8'h35, 2, 8'hE1, 1'b0, "R5 partial rewrite");
      sweep("R5 untouched locations kept");

      // no data byte, then a fragment
      write_cmd(8'h70, 0, 8'h00, 1'b0, "R8 no data");
      quiet("R8 no busy after empty command", WC + 4);
      write_cmd(8'h70, 2, 8'h33, 1'b1, "R8 fragment");
      quiet("R8 no busy after fragment", WC + 4);
      sweep("R8 array unchanged");

      // protection: locked top quarter, then odd addresses
      prot_mode = 1;
      write_cmd(8'hC4, 8, 8'h77, 1'b0, "R9 locked block");
      write_cmd(8'hB8, 8, 8'h90, 1'b0, "R9 open block");
      prot_mode = 2;
      write_cmd(8'h60, 16, 8'h21, 1'b0, "R9 odd locked");
      prot_mode = 0;
      sweep("R9 permission per byte");

      // commands during busy are ignored
      fork
         write_cmd(8'h20, 4, 8'h44, 1'b0, "R10 base");
         begin
            repeat (9) @(negedge clk);
            cs_n = 1'b0;
            @(negedge clk) begin wr_start = 1'b1; start_addr = 8'h10; end
            @(negedge clk) begin wr_start = 1'b0; byte_valid = 1'b1; byte_data = 8'h5A; end
            @(negedge clk) byte_valid = 1'b0;
            @(negedge clk) cs_n = 1'b1;
         end
      join
      quiet("R10 no second cycle", WC + 4);
      sweep("R10 ignored command left page alone");

      // near-exhaustive: one command per page, varied start and length
      for (int p = 0; p < 16; p++)
         if (p != 4'hC && p != 4'hF)
            write_cmd(p * 16 + (p * 5) % 16, (p % 7) + 1 + (p / 8) * 12, 8'h3 * p + 1,
                      1'b0, "R2 page sweep");
      sweep("R2/R3/R4 multi-page contents");

      // registered read timing
      @(negedge clk) rd_addr = 8'h30;
      @(negedge clk) rd_addr = 8'h31;
      #1 check("R11 no change before edge", int'(rd_data), int'(exp_mem[8'h30]));
      @(negedge clk) check("R11 value after edge", int'(rd_data), int'(exp_mem[8'h31]));

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule